// File: doc/BRIEF.md
# Compact-ISA Execute Unit

This block is the execute stage of a small 8-bit register machine with a 4-bit opcode space. It takes the decoded opcode, the two source operand values, the current value of the destination register and the raw short (4-bit) and long (8-bit) immediate fields. In the same combinational pass it produces the value to write back, a write-enable flag, the effective address for loads and stores, and the taken flag of the zero-test branch.

The unit is purely combinational. Register reads, memories, pipeline registers and hazard handling all live in the surrounding stages. Each opcode reads the instruction fields in its own way:

- the increment uses the destination value;
- the shifts take their amount from the short immediate;
- load-immediate takes the long immediate;
- loads and stores add a sign-extended short immediate to the first operand.

Internally, three datapath slices run in parallel: arithmetic, bitwise and shift, and address generation. A control slice picks one result source and sets the flags.

Top module: `tiny_exec_unit`

## Requirements
- R1: Opcodes 0000 add, 0001 subtract, 0100 AND, 0101 OR and 0110 XOR put op(src_a, src_b) on wb_data. Add and subtract wrap modulo 256.
- R2: Opcode 0010 puts the low 8 bits of the product src_a*src_b on wb_data.
- R3: Opcode 0011 puts dst_val+1 modulo 256 on wb_data. src_a and src_b have no effect on it.
- R4: Opcode 0111 puts the bitwise complement of src_a on wb_data.
- R5: Opcodes 1000 (left) and 1001 (right) shift src_a by the unsigned amount in imm_s and fill with zeros. An amount of 8 or more gives 0.
- R6: Opcode 1010 puts imm_l on wb_data unchanged.
- R7: mem_addr always equals src_a plus imm_s sign-extended from 4 bits, modulo 256. Loads (1011) and stores (1100) use this address.
- R8: wb_en is 1 for opcodes 0000 through 1011 and 0 for 1100 through 1111.
- R9: wb_data is 0 for opcodes 1011 through 1111. Load data is merged by a later stage.
- R10: br_taken is 1 exactly when the opcode is 1110 and dst_val is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Instruction opcode |
| src_a | input | 8 | Value of the first source register |
| src_b | input | 8 | Value of the second source register |
| dst_val | input | 8 | Current value of the destination register |
| imm_s | input | 4 | Short immediate (second source field) |
| imm_l | input | 8 | Long immediate (both source fields) |
| wb_data | output | 8 | Result to write back |
| wb_en | output | 1 | Write-back enable |
| mem_addr | output | 8 | Load/store effective address |
| br_taken | output | 1 | Zero-test branch taken |

## Verification
Address generation and the write-back decision are settled in the same evaluation for every opcode. Stores and zero-test branches are therefore the places where the two can disagree.

The bench applies stores whose offsets wrap the address, and requires mem_addr to be correct while wb_en and wb_data stay low. It also applies the branch with a zero destination value and a wrapping address on the operand inputs. There it requires br_taken high, no write, and the address still computed.

A sweep of all sixteen opcodes with fixed operands checks the enable and branch flags against a model written from the requirements.

// File: rtl/tiny_exec_pkg.sv
package tiny_exec_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_MUL  = 4'b0010,
        OP_INC  = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_NOT  = 4'b0111,
        OP_SLLI = 4'b1000,
        OP_SRLI = 4'b1001,
        OP_LI   = 4'b1010,
        OP_LD   = 4'b1011,
        OP_ST   = 4'b1100,
        OP_JMP  = 4'b1101,
        OP_BEQZ = 4'b1110,
        OP_HLT  = 4'b1111
    } opcode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARITH = 2'd1,
        SRC_BITS  = 2'd2,
        SRC_IMM   = 2'd3
    } res_src_e;

endpackage

// File: rtl/tiny_exec_arith.sv
module tiny_exec_arith
    import tiny_exec_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  opcode_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [DW-1:0]    d,
    output logic [DW-1:0]    y
);
    localparam int unsigned PW = 2 * DW;

    logic [PW-1:0] product;

    always_comb begin
        product = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = product[DW-1:0];
            OP_INC:  y = d + {{(DW-1){1'b0}}, 1'b1};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tiny_exec_bitops.sv
module tiny_exec_bitops
    import tiny_exec_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned SW = 4
) (
    input  opcode_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [SW-1:0]    amt,
    output logic [DW-1:0]    y
);
    localparam int unsigned AW = (SW > 32) ? SW : 32;

    logic          amt_big;
    logic [DW-1:0] shl;
    logic [DW-1:0] shr;

    always_comb begin
        amt_big = (AW'(amt) >= AW'(DW));
        shl     = amt_big ? '0 : (a << amt);
        shr     = amt_big ? '0 : (a >> amt);
    end

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SLLI: y = shl;
            OP_SRLI: y = shr;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tiny_exec_agu.sv
module tiny_exec_agu #(
    parameter int unsigned DW = 8,
    parameter int unsigned SW = 4
) (
    input  logic [DW-1:0] base,
    input  logic [SW-1:0] off,
    output logic [DW-1:0] addr
);
    logic [DW-1:0] off_ext;

    generate
        if (DW > SW) begin : g_ext
            assign off_ext = {{(DW-SW){off[SW-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[DW-1:0];
        end
    endgenerate

    assign addr = base + off_ext;
endmodule

// File: rtl/tiny_exec_ctrl.sv
module tiny_exec_ctrl
    import tiny_exec_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  opcode_e       op,
    input  logic [DW-1:0] d,
    output res_src_e      sel,
    output logic          we,
    output logic          taken
);
    always_comb begin
        sel   = SRC_NONE;
        we    = 1'b0;
        taken = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_INC: begin
                sel = SRC_ARITH;
                we  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SLLI, OP_SRLI: begin
                sel = SRC_BITS;
                we  = 1'b1;
            end
            OP_LI: begin
                sel = SRC_IMM;
                we  = 1'b1;
            end
            OP_LD: begin
                we  = 1'b1;
            end
            OP_BEQZ: begin
                taken = (d == '0);
            end
            OP_ST, OP_JMP, OP_HLT: begin
                we  = 1'b0;
            end
            default: begin
                we  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tiny_exec_unit.sv
module tiny_exec_unit
    import tiny_exec_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned SW = 4,
    parameter int unsigned LW = 8
) (
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] dst_val,
    input  logic [SW-1:0] imm_s,
    input  logic [LW-1:0] imm_l,
    output logic [DW-1:0] wb_data,
    output logic          wb_en,
    output logic [DW-1:0] mem_addr,
    output logic          br_taken
);
    opcode_e       op;
    res_src_e      sel;
    logic [DW-1:0] arith_y;
    logic [DW-1:0] bits_y;
    logic [DW-1:0] imm_y;

    assign op = opcode_e'(op_code);

    generate
        if (DW >= LW) begin : g_imm_ext
            assign imm_y = DW'(imm_l);
        end else begin : g_imm_cut
            assign imm_y = imm_l[DW-1:0];
        end
    endgenerate

    tiny_exec_arith #(.DW(DW)) i_arith (
        .op (op),
        .a  (src_a),
        .b  (src_b),
        .d  (dst_val),
        .y  (arith_y)
    );

    tiny_exec_bitops #(.DW(DW), .SW(SW)) i_bits (
        .op  (op),
        .a   (src_a),
        .b   (src_b),
        .amt (imm_s),
        .y   (bits_y)
    );

    tiny_exec_agu #(.DW(DW), .SW(SW)) i_agu (
        .base (src_a),
        .off  (imm_s),
        .addr (mem_addr)
    );

    tiny_exec_ctrl #(.DW(DW)) i_ctrl (
        .op    (op),
        .d     (dst_val),
        .sel   (sel),
        .we    (wb_en),
        .taken (br_taken)
    );

    always_comb begin
        unique case (sel)
            SRC_ARITH: wb_data = arith_y;
            SRC_BITS:  wb_data = bits_y;
            SRC_IMM:   wb_data = imm_y;
            default:   wb_data = '0;
        endcase
    end
endmodule

// File: rtl/tiny_exec_unit_chk.sv
module tiny_exec_unit_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned SW = 4,
    parameter int unsigned LW = 8
) (
    input logic [3:0]    op_code,
    input logic [DW-1:0] src_a,
    input logic [DW-1:0] dst_val,
    input logic [SW-1:0] imm_s,
    input logic [LW-1:0] imm_l,
    input logic [DW-1:0] wb_data,
    input logic          wb_en,
    input logic          br_taken
);
    always_comb begin
        if (!$isunknown({op_code, dst_val, src_a, imm_s, imm_l, wb_data, wb_en, br_taken})) begin
            if (br_taken)
                a_r10_taken_needs_zero: assert (op_code == 4'b1110 && dst_val == '0);
            if (op_code >= 4'b1100)
                a_r8_no_write_upper: assert (!wb_en);
            if (op_code >= 4'b1011)
                a_r9_zero_result: assert (wb_data == '0);
            if (op_code == 4'b0011)
                a_r3_inc_value: assert (wb_data == DW'(dst_val + 1'b1));
            if (op_code == 4'b1010)
                a_r6_li_passes: assert (wb_data == DW'(imm_l));
            if ((op_code == 4'b1000 || op_code == 4'b1001) && 32'(imm_s) >= DW)
                a_r5_big_shift_zero: assert (wb_data == '0);
        end
    end
endmodule

bind tiny_exec_unit tiny_exec_unit_chk #(.DW(DW), .SW(SW), .LW(LW)) i_chk (
    .op_code  (op_code),
    .src_a    (src_a),
    .dst_val  (dst_val),
    .imm_s    (imm_s),
    .imm_l    (imm_l),
    .wb_data  (wb_data),
    .wb_en    (wb_en),
    .br_taken (br_taken)
);

// File: tb/test_tiny_exec_unit.sv
module test_tiny_exec_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = 4'h0;
    logic [7:0] src_a = 8'h00;
    logic [7:0] src_b = 8'h00;
    logic [7:0] dst_val = 8'h00;
    logic [3:0] imm_s = 4'h0;
    logic [7:0] imm_l = 8'h00;
    logic [7:0] wb_data;
    logic       wb_en;
    logic [7:0] mem_addr;
    logic       br_taken;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tiny_exec_unit i_tiny_exec_unit (
        .op_code  (op_code),
        .src_a    (src_a),
        .src_b    (src_b),
        .dst_val  (dst_val),
        .imm_s    (imm_s),
        .imm_l    (imm_l),
        .wb_data  (wb_data),
        .wb_en    (wb_en),
        .mem_addr (mem_addr),
        .br_taken (br_taken)
    );

    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] d, input logic [3:0] s, input logic [7:0] l);
        @(posedge clk);
        op_code = op; src_a = a; src_b = b; dst_val = d; imm_s = s; imm_l = l;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h (op %b)", req, act, exp, op_code);
        end
    endtask

    task automatic t_reset_state;
        chk("R1 reset data", wb_data, 8'h00);
        chk("R8 reset we", {7'b0, wb_en}, 8'h01);
        chk("R7 reset addr", mem_addr, 8'h00);
        chk("R10 reset br", {7'b0, br_taken}, 8'h00);
    endtask

    task automatic t_alu_ops;
        apply(4'b0000, 8'd200, 8'd100, 8'h00, 4'h0, 8'h00); chk("R1 add wrap", wb_data, 8'd44);
        apply(4'b0001, 8'd5, 8'd9, 8'h00, 4'h0, 8'h00);     chk("R1 sub wrap", wb_data, 8'd252);
        apply(4'b0100, 8'hCC, 8'hAA, 8'h00, 4'h0, 8'h00);   chk("R1 and", wb_data, 8'h88);
        apply(4'b0101, 8'hCC, 8'hAA, 8'h00, 4'h0, 8'h00);   chk("R1 or", wb_data, 8'hEE);
        apply(4'b0110, 8'hCC, 8'hAA, 8'h00, 4'h0, 8'h00);   chk("R1 xor", wb_data, 8'h66);
        apply(4'b0010, 8'd20, 8'd13, 8'h00, 4'h0, 8'h00);   chk("R2 mul low", wb_data, 8'h04);
        apply(4'b0010, 8'hFF, 8'hFF, 8'h00, 4'h0, 8'h00);   chk("R2 mul max", wb_data, 8'h01);
        apply(4'b0111, 8'h3C, 8'hFF, 8'h00, 4'h0, 8'h00);   chk("R4 not", wb_data, 8'hC3);
    endtask

    task automatic t_increment;
        apply(4'b0011, 8'h55, 8'h33, 8'h07, 4'h0, 8'h00); chk("R3 inc", wb_data, 8'h08);
        apply(4'b0011, 8'hAA, 8'hCC, 8'h07, 4'h0, 8'h00); chk("R3 inc ignores src", wb_data, 8'h08);
        apply(4'b0011, 8'h00, 8'h00, 8'hFF, 4'h0, 8'h00); chk("R3 inc wrap", wb_data, 8'h00);
    endtask

    task automatic t_shifts;
        apply(4'b1000, 8'h81, 8'h00, 8'h00, 4'd1, 8'h00); chk("R5 sll 1", wb_data, 8'h02);
        apply(4'b1000, 8'h81, 8'h00, 8'h00, 4'd7, 8'h00); chk("R5 sll 7", wb_data, 8'h80);
        apply(4'b1000, 8'hFF, 8'h00, 8'h00, 4'd8, 8'h00); chk("R5 sll 8", wb_data, 8'h00);
        apply(4'b1001, 8'h80, 8'h00, 8'h00, 4'd0, 8'h00); chk("R5 srl 0", wb_data, 8'h80);
        apply(4'b1001, 8'h80, 8'h00, 8'h00, 4'd7, 8'h00); chk("R5 srl 7", wb_data, 8'h01);
        apply(4'b1001, 8'hFF, 8'h00, 8'h00, 4'd15, 8'h00); chk("R5 srl 15", wb_data, 8'h00);
    endtask

    task automatic t_load_imm;
        apply(4'b1010, 8'h12, 8'h34, 8'h56, 4'h3, 8'hA5); chk("R6 li", wb_data, 8'hA5);
        chk("R8 li we", {7'b0, wb_en}, 8'h01);
    endtask

    task automatic t_mem_and_branch;
        apply(4'b1011, 8'h10, 8'h00, 8'h00, 4'hF, 8'h00);
        chk("R7 ld minus1", mem_addr, 8'h0F);
        chk("R8 ld we", {7'b0, wb_en}, 8'h01);
        chk("R9 ld data", wb_data, 8'h00);
        apply(4'b1011, 8'h02, 8'h00, 8'h00, 4'h8, 8'h00); chk("R7 ld minus8 wrap", mem_addr, 8'hFA);
        apply(4'b1100, 8'hFE, 8'h99, 8'h77, 4'h7, 8'h00);
        chk("R7 st plus7 wrap", mem_addr, 8'h05);
        chk("R8 st no write", {7'b0, wb_en}, 8'h00);
        chk("R9 st data", wb_data, 8'h00);
        apply(4'b1110, 8'hFF, 8'h00, 8'h00, 4'h1, 8'h00);
        chk("R10 beqz taken", {7'b0, br_taken}, 8'h01);
        chk("R8 beqz no write", {7'b0, wb_en}, 8'h00);
        chk("R7 beqz addr", mem_addr, 8'h00);
        apply(4'b1110, 8'h00, 8'h00, 8'h01, 4'h0, 8'h00); chk("R10 beqz not taken", {7'b0, br_taken}, 8'h00);
        apply(4'b1101, 8'h00, 8'h00, 8'h00, 4'h0, 8'h00); chk("R10 jmp no test", {7'b0, br_taken}, 8'h00);
    endtask

    task automatic t_sweep;
        for (int k = 0; k < 16; k++) begin
            apply(4'(k), 8'h21, 8'h03, 8'h00, 4'h2, 8'h5A);
            chk("R8 sweep we", {7'b0, wb_en}, (k <= 11) ? 8'h01 : 8'h00);
            chk("R10 sweep br", {7'b0, br_taken}, (k == 14) ? 8'h01 : 8'h00);
            chk("R7 sweep addr", mem_addr, 8'h23);
            if (k >= 11) chk("R9 sweep data", wb_data, 8'h00);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_alu_ops();
        t_increment();
        t_shifts();
        t_load_imm();
        t_mem_and_branch();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule